// File: doc/BRIEF.md
# Compare Unit with Condition Field

This block compares two operands and records the outcome as a four-bit condition code in one of eight slots of a 32-bit condition register. Integer compares run either signed (two's complement) or unsigned, with the second operand taken from a register input or from a 16-bit immediate. Signed compares sign-extend the immediate and unsigned compares zero-extend it. Floating-point compares take two single-precision values and flag the unordered case when a NaN is present.

The condition code holds less, greater and equal flags plus a fourth flag. For integer compares the fourth flag copies a sticky summary-overflow bit. For floating-point compares it marks an unordered result. Software sets or clears the summary-overflow bit through a write port. If that write arrives in the same cycle as an integer compare, the compare records the newly written value. The whole condition register can be read at all times.

Top module: `cmp_cond_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cr_value` is 0 and `so_flag` is 0.
- R2: Slot k (`fld_sel` = k) occupies `cr_value[31-4k : 28-4k]`, so slot 0 is the top nibble. A compare changes only the selected slot, one clock edge after `cmp_valid` is sampled high. With `cmp_valid` low, `cr_value` holds its value.
- R3: Slot encoding: nibble bit 3 = less, bit 2 = greater, bit 1 = equal, bit 0 = overflow copy or unordered. Every ordered compare sets exactly one of bits 3..1.
- R4: With `cmp_kind` = 2'b00 (signed), the operands are compared as two's-complement numbers.
- R5: With `cmp_kind` = 2'b01 (unsigned), the operands are compared as unsigned numbers.
- R6: With `use_imm` = 1 and an integer kind, the second operand is `imm`, sign-extended for kind 00 and zero-extended for kind 01. For floating-point kinds, `use_imm` is ignored and `opb` is used.
- R7: For integer compares, nibble bit 0 equals the summary-overflow value after any write made in the same cycle.
- R8: With `cmp_kind[1]` = 1 (floating point), ordered single-precision values are compared by numeric value. Infinities are included, and +0 equals -0. Nibble bit 0 is 0 regardless of `so_flag`.
- R9: A floating-point compare in which either operand is a NaN (exponent all ones, fraction nonzero) writes the nibble 4'b0001.
- R10: `so_flag` changes only on an edge where `so_wr_en` is high, and then takes `so_wr_val`. Compares never alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Perform a compare this cycle |
| cmp_kind | input | 2 | 00 signed, 01 unsigned, 1x floating point |
| use_imm | input | 1 | Integer second operand from `imm` |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (register) |
| imm | input | 16 | Immediate second operand |
| fld_sel | input | 3 | Destination slot index |
| so_wr_en | input | 1 | Write the summary-overflow bit |
| so_wr_val | input | 1 | Value written to the summary-overflow bit |
| cr_value | output | 32 | Whole condition register |
| so_flag | output | 1 | Summary-overflow bit |

## Verification
The hardest case to reach is a software write to the summary-overflow bit that lands in the same cycle as an integer compare. The compare must record the new value, not the old one. The driver issues both set and clear writes together with compares, and it also issues floating-point compares while the bit is set, which must ignore it. Signed zeros, infinities and NaNs with either sign are aimed at directly. Random traffic then mixes every kind, slot and immediate form.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
   // compare kind encoding: bit1 selects floating point, bit0 selects unsigned
   localparam logic [1:0] KIND_SIGNED   = 2'b00;
   localparam logic [1:0] KIND_UNSIGNED = 2'b01;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic flag;
   } ccode_t;
endpackage

// File: rtl/cmp_int_core.sv
module cmp_int_core #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              is_signed,
   output logic              lt,
   output logic              gt,
   output logic              eq
);
   logic [DATA_W-1:0] key_a, key_b;

   // flipping the sign bit maps two's complement order onto unsigned order
   always_comb begin
      key_a = a;
      key_b = b;
      key_a[DATA_W-1] = a[DATA_W-1] ^ is_signed;
      key_b[DATA_W-1] = b[DATA_W-1] ^ is_signed;
      eq = (key_a == key_b);
      lt = (key_a < key_b);
      gt = !eq && !lt;
   end
endmodule

// File: rtl/cmp_fp_core.sv
module cmp_fp_core #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   output logic                 lt,
   output logic                 gt,
   output logic                 eq,
   output logic                 unord
);
   localparam int W = EXP_W + MAN_W + 1;

   logic              sa, sb, nan_a, nan_b, zero_both, mag_lt, mag_eq;
   logic [W-2:0]      mag_a, mag_b;

   always_comb begin
      sa    = a[W-1];
      sb    = b[W-1];
      mag_a = a[W-2:0];
      mag_b = b[W-2:0];
      nan_a = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
      nan_b = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
      zero_both = (mag_a == '0) && (mag_b == '0);
      mag_lt = (mag_a < mag_b);
      mag_eq = (mag_a == mag_b);
      unord = nan_a || nan_b;
      lt = 1'b0;
      gt = 1'b0;
      eq = 1'b0;
      if (!unord) begin
         if (zero_both || (sa == sb && mag_eq)) begin
            eq = 1'b1;
         end else if (sa != sb) begin
            lt = sa;
            gt = sb;
         end else begin
            // equal signs: magnitude order, reversed for negatives
            lt = mag_lt ^ sa;
            gt = !(mag_lt ^ sa);
         end
      end
   end
endmodule

// File: rtl/cmp_cr_file.sv
module cmp_cr_file #(
   parameter int NFIELD = 8,
   parameter int FW     = 4,
   localparam int IDX_W = (NFIELD > 1) ? $clog2(NFIELD) : 1,
   localparam int CR_W  = NFIELD * FW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [FW-1:0]    wr_data,
   output logic [CR_W-1:0]  cr_q
);
   // slot 0 sits in the most significant nibble
   for (genvar k = 0; k < NFIELD; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cr_q[CR_W-1-k*FW -: FW] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(k)) begin
            cr_q[CR_W-1-k*FW -: FW] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int NFIELD = 8,
   parameter bit FP_EN  = 1'b1,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   localparam int IDX_W = (NFIELD > 1) ? $clog2(NFIELD) : 1,
   localparam int FW    = 4,
   localparam int CR_W  = NFIELD * FW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_valid,
   input  logic [1:0]        cmp_kind,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IMM_W-1:0]  imm,
   input  logic [IDX_W-1:0]  fld_sel,
   input  logic              so_wr_en,
   input  logic              so_wr_val,
   output logic [CR_W-1:0]   cr_value,
   output logic              so_flag
);
   import cmp_pkg::*;

   if (IMM_W > DATA_W || IMM_W < 1) begin : g_bad_imm
      $error("cmp_cond_unit: IMM_W must be between 1 and DATA_W");
   end
   if (FP_EN && (EXP_W + MAN_W + 1 != DATA_W)) begin : g_bad_fp
      $error("cmp_cond_unit: float format must fill DATA_W");
   end

   logic              is_fp, is_signed, so_next;
   logic [DATA_W-1:0] imm_ext, b_int;
   logic              i_lt, i_gt, i_eq;
   logic              f_lt, f_gt, f_eq, f_un;
   ccode_t            code;

   assign is_fp     = cmp_kind[1];
   assign is_signed = (cmp_kind == KIND_SIGNED);

   // immediate widening follows the signedness of the compare
   assign imm_ext = is_signed ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm}
                              : {{(DATA_W-IMM_W){1'b0}}, imm};
   assign b_int   = use_imm ? imm_ext : opb;

   cmp_int_core #(.DATA_W(DATA_W)) u_int (
      .a(opa), .b(b_int), .is_signed(is_signed),
      .lt(i_lt), .gt(i_gt), .eq(i_eq)
   );

   if (FP_EN) begin : g_fp
      cmp_fp_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fp (
         .a(opa), .b(opb), .lt(f_lt), .gt(f_gt), .eq(f_eq), .unord(f_un)
      );
   end else begin : g_no_fp
      // without float support the float kinds fall back to the integer result
      assign f_lt = i_lt;
      assign f_gt = i_gt;
      assign f_eq = i_eq;
      assign f_un = 1'b0;
   end

   // sticky overflow summary: only software moves it
   assign so_next = so_wr_en ? so_wr_val : so_flag;

   always_ff @(posedge clk) begin
      if (!rst_n) so_flag <= 1'b0;
      else        so_flag <= so_next;
   end

   always_comb begin
      if (is_fp && FP_EN) begin
         code = '{lt: f_lt, gt: f_gt, eq: f_eq, flag: f_un};
      end else begin
         code = '{lt: i_lt, gt: i_gt, eq: i_eq, flag: so_next};
      end
   end

   cmp_cr_file #(.NFIELD(NFIELD), .FW(FW)) u_cr (
      .clk(clk), .rst_n(rst_n), .wr_en(cmp_valid), .wr_idx(fld_sel),
      .wr_data(code), .cr_q(cr_value)
   );
endmodule

// File: rtl/cmp_cond_chk.sv
module cmp_cond_chk #(
   parameter int DATA_W = 32,
   parameter int NFIELD = 8,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   localparam int IDX_W = (NFIELD > 1) ? $clog2(NFIELD) : 1,
   localparam int FW    = 4,
   localparam int CR_W  = NFIELD * FW
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_valid,
   input logic [1:0]        cmp_kind,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [IDX_W-1:0]  fld_sel,
   input logic              so_wr_en,
   input logic [CR_W-1:0]   cr_value,
   input logic              so_flag
);
   logic [IDX_W-1:0] idx_q;
   logic [FW-1:0]    nib;
   logic             nan_in;

   always_ff @(posedge clk) idx_q <= fld_sel;

   assign nib = cr_value[CR_W-1-idx_q*FW -: FW];
   assign nan_in = cmp_kind[1] &&
      (((&opa[DATA_W-2:MAN_W]) && (|opa[MAN_W-1:0])) ||
       ((&opb[DATA_W-2:MAN_W]) && (|opb[MAN_W-1:0])));

   // R2
   cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> $stable(cr_value));

   // R3
   code_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> ($countones(nib[3:1]) == 1) ||
                    ($past(cmp_kind[1]) && nib == 4'b0001));

   // R7
   int_so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !cmp_kind[1]) |=> nib[0] == so_flag);

   // R9
   fp_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && nan_in) |=> nib == 4'b0001);

   // R10
   so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !so_wr_en |=> $stable(so_flag));
endmodule

bind cmp_cond_unit cmp_cond_chk #(
   .DATA_W(DATA_W), .NFIELD(NFIELD), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
   .opa(opa), .opb(opb), .fld_sel(fld_sel), .so_wr_en(so_wr_en),
   .cr_value(cr_value), .so_flag(so_flag)
);

// File: tb/test_cmp_cond_unit.sv
`timescale 1ns/1ps
module test_cmp_cond_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic [1:0]  cmp_kind = 2'b00;
   logic        use_imm = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic [15:0] imm = '0;
   logic [2:0]  fld_sel = '0;
   logic        so_wr_en = 1'b0, so_wr_val = 1'b0;
   logic [31:0] cr_value;
   logic        so_flag;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] cr;
      logic        so;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   logic [31:0] m_cr = '0;
   logic        m_so = 1'b0;

   always #2.5 clk = ~clk;

   cmp_cond_unit i_cmp_cond_unit (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
      .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm), .fld_sel(fld_sel),
      .so_wr_en(so_wr_en), .so_wr_val(so_wr_val), .cr_value(cr_value),
      .so_flag(so_flag)
   );

   function automatic logic [31:0] fkey(logic [31:0] x);
      if (x[30:0] == 0) return 32'h8000_0000;
      if (x[31])        return ~x;
      return x | 32'h8000_0000;
   endfunction

   function automatic bit is_nan(logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected state
   task automatic drive(bit v, logic [1:0] k, bit ui, logic [31:0] a,
                        logic [31:0] b, logic [15:0] im, logic [2:0] f,
                        bit sw, bit sv, string tag);
      logic [31:0] bb;
      logic [3:0]  nib;
      logic        nso;
      exp_t        e;
      @(negedge clk);
      cmp_valid = v; cmp_kind = k; use_imm = ui; opa = a; opb = b;
      imm = im; fld_sel = f; so_wr_en = sw; so_wr_val = sv;
      nso = sw ? sv : m_so;
      if (k[1]) begin
         if (is_nan(a) || is_nan(b)) nib = 4'b0001;
         else if (fkey(a) < fkey(b)) nib = 4'b1000;
         else if (fkey(a) > fkey(b)) nib = 4'b0100;
         else nib = 4'b0010;
      end else begin
         if (ui) bb = (k == 2'b00) ? {{16{im[15]}}, im} : {16'h0, im};
         else    bb = b;
         if (k == 2'b00)
            nib = ($signed(a) < $signed(bb)) ? 4'b1000 :
                  ($signed(a) > $signed(bb)) ? 4'b0100 : 4'b0010;
         else
            nib = (a < bb) ? 4'b1000 : (a > bb) ? 4'b0100 : 4'b0010;
         nib[0] = nso;
      end
      if (v) m_cr[31-4*f -: 4] = nib;
      m_so = nso;
      e.cr = m_cr; e.so = m_so; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic cmp(logic [1:0] k, bit ui, logic [31:0] a, logic [31:0] b,
                      logic [15:0] im, logic [2:0] f, string tag);
      drive(1'b1, k, ui, a, b, im, f, 1'b0, 1'b0, tag);
   endtask

   // monitor: compares each queued expectation after its clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(cr_value == e.cr && so_flag == e.so, e.tag,
                  {so_flag, cr_value}, {e.so, e.cr});
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cr_value == 0 && so_flag == 0, "R1 in reset",
            {so_flag, cr_value}, 33'h0);
      rst_n = 1'b1;
      drive(1'b0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1 after reset");
      // R4 signed and R5 unsigned on the same bits
      cmp(2'b00, 0, 32'hFFFF_FFFB, 32'd3, 0, 3'd0, "R4 neg<pos");
      cmp(2'b01, 0, 32'hFFFF_FFFB, 32'd3, 0, 3'd1, "R5 big>small");
      cmp(2'b00, 0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 3'd2, "R4 min<max");
      cmp(2'b01, 0, 32'h1234, 32'h1234, 0, 3'd3, "R3 equal");
      // R6 immediate widening
      cmp(2'b00, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 3'd4, "R6 signed imm");
      cmp(2'b01, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 3'd5, "R6 unsigned imm");
      cmp(2'b01, 1, 32'h0000_FFFF, 32'h0, 16'hFFFF, 3'd6, "R6 unsigned eq");
      cmp(2'b10, 1, 32'h3F80_0000, 32'h4000_0000, 16'h0, 3'd7, "R6 fp ignores imm");
      // R2 idle cycles keep everything
      drive(1'b0, 2'b00, 0, 32'h5, 32'h9, 0, 3'd0, 0, 0, "R2 idle hold");
      drive(1'b0, 2'b10, 0, 32'h7FC0_0000, 32'h0, 0, 3'd7, 0, 0, "R2 idle hold fp");
      // R7 same-cycle overflow write and compare
      drive(1'b1, 2'b00, 0, 32'd1, 32'd1, 0, 3'd0, 1, 1, "R7 set with compare");
      cmp(2'b01, 0, 32'd2, 32'd1, 0, 3'd1, "R7 sticky copy");
      cmp(2'b10, 0, 32'h8000_0000, 32'h0000_0000, 0, 3'd2, "R8 -0 eq +0 ignores so");
      drive(1'b0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R10 holds after compares");
      drive(1'b1, 2'b00, 0, 32'd1, 32'd2, 0, 3'd3, 1, 0, "R7 clear with compare");
      drive(1'b0, 2'b00, 0, 0, 0, 0, 0, 1, 1, "R10 write alone");
      // R8 ordering
      cmp(2'b10, 0, 32'hFF80_0000, 32'hBF80_0000, 0, 3'd4, "R8 -inf<-1");
      cmp(2'b10, 0, 32'hC000_0000, 32'hBF80_0000, 0, 3'd5, "R8 -2<-1");
      cmp(2'b11, 0, 32'h7F80_0000, 32'h4000_0000, 0, 3'd6, "R8 +inf>2");
      cmp(2'b10, 0, 32'h8000_0001, 32'h0000_0000, 0, 3'd7, "R8 -tiny<0");
      // R9 NaN on either side
      cmp(2'b10, 0, 32'h7FC0_0000, 32'h3F80_0000, 0, 3'd0, "R9 nan a");
      cmp(2'b10, 0, 32'h3F80_0000, 32'hFF80_0001, 0, 3'd1, "R9 nan b");
      cmp(2'b10, 0, 32'h7F80_0000, 32'h7F80_0000, 0, 3'd2, "R9 inf not nan");
      // R2 every slot position
      for (int s = 0; s < 8; s++)
         cmp(2'b00, 0, 32'(s), 32'd4, 0, 3'(s), "R2 slot sweep");
      // mixed random traffic
      for (int n = 0; n < 400; n++) begin
         logic [31:0] ra, rb;
         ra = $urandom;
         rb = ($urandom % 4 == 0) ? ra : $urandom;
         drive(1'($urandom % 4 != 0), 2'($urandom), 1'($urandom),
               ra, rb, 16'($urandom), 3'($urandom),
               1'($urandom % 8 == 0), 1'($urandom), "R3 random mix");
      end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule